// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit register datapath and a byte-addressed data memory that is one word wide. For a store, it copies the register value onto the byte lanes that match the access size and the low address bits. It also produces a byte-enable mask, so that only the addressed bytes of the memory word are written. For a load, it takes the word that memory returns and picks out the addressed byte or halfword. The result is right-justified and then zero-extended or sign-extended to the full register width.

A run-time mode input chooses how address offsets map onto lanes. In little-endian numbering, offset k is lane k. In big-endian numbering, offset k is the mirrored lane. A whole word passes through unchanged in either mode. Accesses that break natural alignment are flagged. They never write memory and they return zero. All results come out of a register one clock after the request.

Top module: `lsu_lane_align`

## Requirements
- R1: A word access (size code 2'b10) whose offset bits [1:0] are not 2'b00 raises rsp_misalign.
- R2: A halfword access (size code 2'b01) with offset bit 0 set raises rsp_misalign. A byte access (size code 2'b00) is never misaligned.
- R3: Size code 2'b11 is illegal at any offset and raises rsp_misalign.
- R4: When rsp_misalign is high, mem_be is 4'b0000 and ld_data is zero.
- R5: Unsigned byte load (req_signed=0), little-endian: ld_data[7:0] = mem_rdata[8k+7:8k] for offset k, and ld_data[31:8] = 0. A word load returns mem_rdata unchanged in both modes.
- R6: Unsigned halfword load, little-endian: offset 0 returns mem_rdata[15:0], offset 2 returns mem_rdata[31:16], and ld_data[31:16] = 0.
- R7: A signed load (req_signed=1) copies bit 7 of the byte into ld_data[31:8], or bit 15 of the halfword into ld_data[31:16].
- R8: Byte store: mem_wdata is req_wdata[7:0] repeated in all four lanes, and mem_be has exactly the bit of the addressed lane set (little-endian lane = offset). Loads leave mem_be at 4'b0000.
- R9: Halfword store: mem_wdata is req_wdata[15:0] repeated twice. mem_be is 4'b0011 for offset 0 or 4'b1100 for offset 2 (little-endian).
- R10: Word store at offset 0: mem_wdata equals req_wdata and mem_be is 4'b1111, whatever the lane mode.
- R11: With cfg_big_endian=1, byte offset k uses lane 3-k, and halfword offset 0 uses lanes 3:2 while offset 2 uses lanes 1:0. For example, a byte load at offset 0 of word 0x11223344 returns 0x44 in little-endian mode and 0x11 in big-endian mode.
- R12: Every output is registered. rsp_valid follows req_valid one cycle later. In a cycle with no response, mem_be is 0 and rsp_misalign is 0.
- R13: A synchronous active-high reset clears rsp_valid, rsp_misalign, mem_be, mem_wdata and ld_data. They stay clear while rst is held, even if requests arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| req_signed | input | 1 | Sign-extend a sub-word load (ignored for stores) |
| cfg_big_endian | input | 1 | 0 = little-endian lane numbering, 1 = big-endian |
| req_ofs | input | 2 | Low address bits (byte offset within the word) |
| req_wdata | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word returned by memory for a load, same cycle as the request |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_be | output | 4 | Byte enables, bit i = lane i (bits 8i+7:8i) |
| ld_data | output | 32 | Extended load result |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_misalign | output | 1 | Alignment error for the responded request |

## Verification
The bench targets the three ways lanes can be mis-mapped:
- A design that ignores the lane mode returns 0x44 where 0x11 is expected.
- A design that mirrors a halfword by bytes instead of by halves returns swapped bytes.
- A design that uses the wrong halfword index enables lanes 1:0 where lanes 3:2 are expected.

Sign extension is tested with high-bit-set bytes and halfwords in both signed and unsigned form, so a design that extends with zeros, or picks the sign bit from the wrong lane, shows the wrong upper bits.

Misaligned words, odd halfwords and the illegal size code are each sent as both stores and loads. A design that still asserts any byte enable there would corrupt memory, and the bench sees that enable directly.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int OFS_W = 2
) (
  input  lsu_pkg::size_e   size,
  input  logic [OFS_W-1:0] ofs,
  output logic             mis
);
  always_comb begin
    unique case (size)
      lsu_pkg::SZ_BYTE: mis = 1'b0;
      lsu_pkg::SZ_HALF: mis = ofs[0];
      lsu_pkg::SZ_WORD: mis = |ofs;
      default:          mis = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  lsu_pkg::size_e    size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              big_end,
  input  logic              write,
  input  logic              mis,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rep_data,
  output logic [LANES-1:0]  be
);
  logic [OFS_W-1:0] blane;
  logic [OFS_W-2:0] hidx;
  logic [OFS_W-1:0] lane_last;

  assign lane_last = OFS_W'(LANES - 1);
  assign blane = big_end ? (lane_last - ofs) : ofs;
  assign hidx  = big_end ? ~ofs[OFS_W-1:1] : ofs[OFS_W-1:1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (size)
        lsu_pkg::SZ_BYTE: rep_data[8*g +: 8] = wdata[7:0];
        lsu_pkg::SZ_HALF: rep_data[8*g +: 8] = wdata[8*(g%2) +: 8];
        default:          rep_data[8*g +: 8] = wdata[8*g +: 8];
      endcase
    end
  end

  always_comb begin
    be = '0;
    if (write && !mis) begin
      unique case (size)
        lsu_pkg::SZ_BYTE: be = LANES'(1) << blane;
        lsu_pkg::SZ_HALF: be = LANES'(3) << {hidx, 1'b0};
        default:          be = '1;
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  lsu_pkg::size_e    size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              big_end,
  input  logic              sgn,
  input  logic              mis,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ldata
);
  logic [OFS_W-1:0]  blane;
  logic [OFS_W-2:0]  hidx;
  logic [OFS_W-1:0]  lane_last;
  logic [DATA_W-1:0] byte_sh, half_sh;

  assign lane_last = OFS_W'(LANES - 1);
  assign blane   = big_end ? (lane_last - ofs) : ofs;
  assign hidx    = big_end ? ~ofs[OFS_W-1:1] : ofs[OFS_W-1:1];
  assign byte_sh = rdata >> {blane, 3'b000};
  assign half_sh = rdata >> {hidx, 4'b0000};

  always_comb begin
    ldata = '0;
    if (!mis) begin
      unique case (size)
        lsu_pkg::SZ_BYTE:
          ldata = {{(DATA_W-8){sgn & byte_sh[7]}}, byte_sh[7:0]};
        lsu_pkg::SZ_HALF:
          ldata = {{(DATA_W-16){sgn & half_sh[15]}}, half_sh[15:0]};
        default:
          ldata = rdata;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              cfg_big_endian,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] ld_data,
  output logic              rsp_valid,
  output logic              rsp_misalign
);
  lsu_pkg::size_e    size;
  logic              mis;
  logic [DATA_W-1:0] rep_data, ext_data;
  logic [LANES-1:0]  be_c;

  assign size = lsu_pkg::size_e'(req_size);

  lsu_align_chk #(.OFS_W(OFS_W)) u_chk (
    .size(size), .ofs(req_ofs), .mis(mis)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_st (
    .size(size), .ofs(req_ofs), .big_end(cfg_big_endian),
    .write(req_write), .mis(mis), .wdata(req_wdata),
    .rep_data(rep_data), .be(be_c)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size(size), .ofs(req_ofs), .big_end(cfg_big_endian),
    .sgn(req_signed), .mis(mis), .rdata(mem_rdata), .ldata(ext_data)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid    <= 1'b0;
      rsp_misalign <= 1'b0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      ld_data      <= '0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_misalign <= mis;
      mem_be       <= be_c;
      mem_wdata    <= rep_data;
      ld_data      <= req_write ? '0 : ext_data;
    end
  end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              req_signed,
  input logic [OFS_W-1:0]  req_ofs,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] ld_data,
  input logic              rsp_valid,
  input logic              rsp_misalign
);
  assert_word_mis_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b10 && req_ofs != '0) |=> rsp_misalign);

  assert_half_mis_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b01 && req_ofs[0]) |=> rsp_misalign);

  assert_bad_size_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b11) |=> rsp_misalign);

  assert_mis_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_misalign |-> (mem_be == '0 && ld_data == '0));

  assert_ubyte_zext_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'b00 && !req_signed)
      |=> ld_data[DATA_W-1:8] == '0);

  assert_shalf_sext_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'b01 && req_signed && !req_ofs[0])
      |=> ld_data[DATA_W-1:16] == {(DATA_W-16){ld_data[15]}});

  assert_be_shape_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(mem_be) != 3);

  assert_word_store_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_size == 2'b10 && req_ofs == '0)
      |=> (mem_be == '1 && mem_wdata == $past(req_wdata)));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (mem_be == '0 && !rsp_misalign));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_signed(req_signed), .req_ofs(req_ofs),
  .req_wdata(req_wdata), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .ld_data(ld_data), .rsp_valid(rsp_valid), .rsp_misalign(rsp_misalign)
);

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
  localparam int PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic        sg;
    logic        bm;
    logic [1:0]  of;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [31:0] xwd;
    logic [3:0]  xbe;
    logic [31:0] xld;
    logic        xmis;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [31:0] P = 32'h11223344;
  localparam logic [31:0] N = 32'h8899AABB;

  localparam vec_t VT [NV] = '{
    '{1'b0,2'd0,1'b0,1'b0,2'd0,32'h0,P,32'h0,4'h0,32'h00000044,1'b0,8'd5},  // R5
    '{1'b0,2'd0,1'b0,1'b1,2'd0,32'h0,P,32'h0,4'h0,32'h00000011,1'b0,8'd11}, // R11
    '{1'b0,2'd0,1'b0,1'b0,2'd3,32'h0,N,32'h0,4'h0,32'h00000088,1'b0,8'd5},  // R5
    '{1'b0,2'd0,1'b1,1'b0,2'd1,32'h0,N,32'h0,4'h0,32'hFFFFFFAA,1'b0,8'd7},  // R7
    '{1'b0,2'd0,1'b1,1'b0,2'd2,32'h0,P,32'h0,4'h0,32'h00000022,1'b0,8'd7},  // R7
    '{1'b0,2'd1,1'b0,1'b0,2'd2,32'h0,N,32'h0,4'h0,32'h00008899,1'b0,8'd6},  // R6
    '{1'b0,2'd1,1'b0,1'b0,2'd0,32'h0,N,32'h0,4'h0,32'h0000AABB,1'b0,8'd6},  // R6
    '{1'b0,2'd1,1'b1,1'b0,2'd0,32'h0,N,32'h0,4'h0,32'hFFFFAABB,1'b0,8'd7},  // R7
    '{1'b0,2'd1,1'b1,1'b1,2'd0,32'h0,N,32'h0,4'h0,32'hFFFF8899,1'b0,8'd11}, // R11
    '{1'b0,2'd1,1'b0,1'b1,2'd2,32'h0,N,32'h0,4'h0,32'h0000AABB,1'b0,8'd11}, // R11
    '{1'b0,2'd0,1'b1,1'b1,2'd3,32'h0,N,32'h0,4'h0,32'hFFFFFFBB,1'b0,8'd11}, // R11
    '{1'b0,2'd2,1'b0,1'b0,2'd0,32'h0,N,32'h0,4'h0,N,1'b0,8'd5},            // R5 word
    '{1'b0,2'd2,1'b1,1'b1,2'd0,32'h0,N,32'h0,4'h0,N,1'b0,8'd5},            // R5 word BE
    '{1'b0,2'd2,1'b0,1'b0,2'd1,32'h0,N,32'h0,4'h0,32'h0,1'b1,8'd1},        // R1 R4
    '{1'b0,2'd1,1'b1,1'b0,2'd3,32'h0,N,32'h0,4'h0,32'h0,1'b1,8'd2},        // R2 R4
    '{1'b0,2'd3,1'b0,1'b0,2'd0,32'h0,N,32'h0,4'h0,32'h0,1'b1,8'd3},        // R3
    '{1'b1,2'd0,1'b0,1'b0,2'd2,32'hCAFEBE5A,N,32'h5A5A5A5A,4'b0100,32'h0,1'b0,8'd8},  // R8
    '{1'b1,2'd0,1'b1,1'b1,2'd2,32'hCAFEBE5A,N,32'h5A5A5A5A,4'b0010,32'h0,1'b0,8'd11}, // R11
    '{1'b1,2'd1,1'b0,1'b0,2'd2,32'h1234ABCD,N,32'hABCDABCD,4'b1100,32'h0,1'b0,8'd9},  // R9
    '{1'b1,2'd1,1'b0,1'b1,2'd2,32'h1234ABCD,N,32'hABCDABCD,4'b0011,32'h0,1'b0,8'd11}, // R11
    '{1'b1,2'd2,1'b0,1'b1,2'd0,P,N,P,4'b1111,32'h0,1'b0,8'd10},            // R10
    '{1'b1,2'd2,1'b0,1'b0,2'd2,P,N,32'h0,4'b0000,32'h0,1'b1,8'd1},         // R1 R4
    '{1'b1,2'd1,1'b0,1'b0,2'd1,P,N,32'h0,4'b0000,32'h0,1'b1,8'd2},         // R2 R4
    '{1'b1,2'd3,1'b0,1'b0,2'd0,P,N,32'h0,4'b0000,32'h0,1'b1,8'd3}          // R3
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, cfg_big_endian = 1'b0;
  logic [1:0] req_size = 2'd0, req_ofs = 2'd0;
  logic [31:0] req_wdata = '0, mem_rdata = '0;
  logic [31:0] mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic rsp_valid, rsp_misalign;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lsu_lane_align u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .cfg_big_endian(cfg_big_endian),
    .req_ofs(req_ofs), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .ld_data(ld_data),
    .rsp_valid(rsp_valid), .rsp_misalign(rsp_misalign)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1; req_write = v.we; req_size = v.sz; req_signed = v.sg;
    cfg_big_endian = v.bm; req_ofs = v.of; req_wdata = v.wd; mem_rdata = v.rd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R13: requests during reset leave outputs clear
    drive(VT[20]);
    repeat (3) @(negedge clk);
    chk("R13 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    chk("R13 mem_be in reset", {28'b0, mem_be}, 32'd0);
    chk("R13 mem_wdata in reset", mem_wdata, 32'd0);
    chk("R13 ld_data/misalign in reset", ld_data | {31'b0, rsp_misalign}, 32'd0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    // R12: idle cycle gives no response and no enables
    chk("R12 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R12 idle mem_be", {28'b0, mem_be}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(negedge clk);
      chk($sformatf("R12 v%0d rsp_valid (R%0d)", i, VT[i].rq), {31'b0, rsp_valid}, 32'd1);
      chk($sformatf("v%0d misalign (R%0d)", i, VT[i].rq), {31'b0, rsp_misalign}, {31'b0, VT[i].xmis});
      chk($sformatf("v%0d mem_be (R%0d)", i, VT[i].rq), {28'b0, mem_be}, {28'b0, VT[i].xbe});
      if (VT[i].we && !VT[i].xmis)
        chk($sformatf("v%0d mem_wdata (R%0d)", i, VT[i].rq), mem_wdata, VT[i].xwd);
      if (!VT[i].we)
        chk($sformatf("v%0d ld_data (R%0d)", i, VT[i].rq), ld_data, VT[i].xld);
    end

    // R12: back to idle after traffic
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 idle after traffic rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R12 idle after traffic misalign", {31'b0, rsp_misalign}, 32'd0);

    // R8: a load with byte size never enables lanes; R2: byte at odd offset legal
    drive(VT[3]);
    req_write = 1'b0; req_ofs = 2'd1;
    @(negedge clk);
    chk("R8 load mem_be", {28'b0, mem_be}, 32'd0);
    chk("R2 byte odd legal", {31'b0, rsp_misalign}, 32'd0);

    // R13: reset asserted mid-stream clears registered outputs
    drive(VT[20]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R13 mid reset mem_be", {28'b0, mem_be}, 32'd0);
    chk("R13 mid reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule